// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a 32-bit processor core and a shared 32-bit external data bus. The ports on that bus differ in width: 8, 16 or 32 bits. The core hands the block one longword read or write. The block then runs as many external bus cycles as the addressed port needs to move all four bytes. The target ends each bus cycle with a two-line acknowledge. The code it returns states how many bits it took or supplied in that cycle. The address decoder chooses that code per region, so one bus can carry a byte-wide peripheral, a halfword-wide ROM and a full-width RAM.

Narrow ports sit on the upper byte lanes. After a partial acknowledge on a write, the block shifts the bytes still owed onto those upper lanes, advances the address by the number of bytes already moved and starts a new cycle. On a read, it collects the bytes from the active lanes of each cycle into their big-endian positions in one result longword.

On the core side, requests use a valid/ready handshake. `req_ready` is high only while the block is idle, and a request is taken on a clock where `req_valid` and `req_ready` are both high. The completion is also valid/ready. `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low, which is how the core applies back-pressure. Only one transfer is in flight at a time.

Top module: `dbs_sequencer`

## Requirements
- R1: After reset `req_ready` is 1 and `bus_strobe` and `rsp_valid` are 0. A request accepted on a clock edge makes `bus_strobe` 1 from the next cycle. In that cycle `bus_addr` equals `req_addr`, `bus_write` equals `req_write`, and on a write `bus_wdata` carries the whole operand.
- R2: `bus_ack` is {line1, line0}. 2'b11 means 4 bytes, 2'b10 means 2 bytes on bits 31:16, 2'b01 means 1 byte on bits 31:24, and 2'b00 means wait. While the code is 2'b00, the strobe, address, write flag and write data all hold.
- R3: `bus_strobe` goes low in the cycle after a non-zero acknowledge is sampled. A non-zero acknowledge seen while the strobe is low has no effect on any output.
- R4: After a partial acknowledge the strobe stays low for exactly one cycle and then rises again. The new cycle's address is the start address plus the bytes moved so far. The new cycle's write data is the leftover bytes shifted up by the accepted width, so the target receives the operand bytes in order, most significant first.
- R5: The number of bytes counted per cycle is the acknowledged width, capped at the bytes still owed. A longword therefore needs one cycle on a 32-bit port, two on a 16-bit port and four on an 8-bit port. Widths may change from one cycle to the next, and a 4-byte acknowledge always ends the transfer.
- R6: On a read, bus lane j (bits 31-8j down to 24-8j) of a cycle that starts at byte offset d fills result byte d+j, where result byte 0 is bits 31:24. Lanes beyond the accepted width are ignored.
- R7: `rsp_valid` rises in the cycle after the final acknowledge. It holds, with a stable `rsp_rdata`, until `rsp_ready` is seen. The next cycle is idle with `req_ready` high. `rsp_rdata` is 0 for writes.
- R8: Exactly one of `req_ready`, `bus_strobe` and `rsp_valid` is high in every cycle after reset, apart from the single-cycle gap between bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core offers a longword request |
| req_ready | output | 1 | Block is idle and takes the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Longword start address |
| req_wdata | input | DATA_W | Write operand |
| rsp_valid | output | 1 | Transfer complete |
| rsp_ready | input | 1 | Core takes the completion |
| rsp_rdata | output | DATA_W | Assembled read longword (0 on writes) |
| bus_strobe | output | 1 | Bus cycle active |
| bus_write | output | 1 | Direction of the current bus cycle |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_wdata | output | DATA_W | Write data, leftover bytes on upper lanes |
| bus_rdata | input | DATA_W | Read data from the target |
| bus_ack | input | 2 | Width acknowledge {line1, line0} |

## Verification
Several checks run on every clock. They cover the one-hot phase of ready, strobe and response, the hold of strobe and address during wait states, the strobe release after any acknowledge, the reissue after the one-cycle gap, the end of a transfer after a full-width acknowledge, and the stability of a stalled response. Other behaviour is only visible over whole transfers, so the bench scenarios have to show it. That covers byte ordering through the lane shifts, address stepping, result assembly from mixed-width ports, cycle counts per port width, and the fact that acknowledges outside a strobe and garbage on unused lanes change nothing.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CYCLE = 2'd1,
    ST_GAP   = 2'd2,
    ST_RESP  = 2'd3
  } seq_state_t;

  localparam logic [1:0] ACK_WAIT = 2'b00;
  localparam logic [1:0] ACK_BYTE = 2'b01;
  localparam logic [1:0] ACK_HALF = 2'b10;
  localparam logic [1:0] ACK_FULL = 2'b11;
endpackage

// File: rtl/dbs_ack_decode.sv
module dbs_ack_decode #(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 3
) (
  input  logic [1:0]       ack,
  input  logic [CNT_W-1:0] remaining,
  output logic             hit,
  output logic [CNT_W-1:0] taken
);
  import dbs_pkg::*;

  localparam int HALF_LANES = (NUM_LANES > 1) ? NUM_LANES / 2 : 1;

  logic [CNT_W-1:0] width;

  always_comb begin
    unique case (ack)
      ACK_FULL: width = CNT_W'(NUM_LANES);
      ACK_HALF: width = CNT_W'(HALF_LANES);
      ACK_BYTE: width = CNT_W'(1);
      default:  width = '0;
    endcase
  end

  assign hit   = (ack != ACK_WAIT);
  assign taken = (width > remaining) ? remaining : width;
endmodule

// File: rtl/dbs_lane_shift.sv
module dbs_lane_shift #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 3,
  localparam int DATA_W   = LANE_W * NUM_LANES
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  shift,
  output logic [DATA_W-1:0] dout
);
  logic [LANE_W-1:0] in_lane [NUM_LANES];

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_split
    assign in_lane[j] = din[DATA_W-1-LANE_W*j -: LANE_W];
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_out
    logic [LANE_W-1:0] lane_q;
    always_comb begin
      lane_q = '0;
      for (int s = 0; s < NUM_LANES - j; s++) begin
        if (int'(shift) == s) lane_q = in_lane[j+s];
      end
    end
    assign dout[DATA_W-1-LANE_W*j -: LANE_W] = lane_q;
  end
endmodule

// File: rtl/dbs_read_merge.sv
module dbs_read_merge #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 3,
  localparam int DATA_W   = LANE_W * NUM_LANES
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [CNT_W-1:0]  base,
  input  logic [CNT_W-1:0]  taken,
  output logic [DATA_W-1:0] merged
);
  logic [LANE_W-1:0] bus_lane [NUM_LANES];

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_split
    assign bus_lane[j] = bus_data[DATA_W-1-LANE_W*j -: LANE_W];
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_pos
    logic [LANE_W-1:0] pos_q;
    always_comb begin
      pos_q = acc[DATA_W-1-LANE_W*k -: LANE_W];
      for (int j = 0; j <= k; j++) begin
        if (j < int'(taken) && int'(base) + j == k) pos_q = bus_lane[j];
      end
    end
    assign merged[DATA_W-1-LANE_W*k -: LANE_W] = pos_q;
  end
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        bus_ack
);
  import dbs_pkg::*;

  localparam int NUM_LANES = DATA_W / LANE_W;
  localparam int CNT_W     = $clog2(NUM_LANES + 1);

  seq_state_t        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [CNT_W-1:0]  done_q;
  logic              write_q;

  logic [CNT_W-1:0]  remaining;
  logic [CNT_W-1:0]  taken;
  logic [CNT_W-1:0]  next_done;
  logic              ack_hit;
  logic [DATA_W-1:0] wdata_shifted;
  logic [DATA_W-1:0] rdata_merged;

  assign remaining = CNT_W'(NUM_LANES) - done_q;
  assign next_done = done_q + taken;

  dbs_ack_decode #(.NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_decode (
    .ack       (bus_ack),
    .remaining (remaining),
    .hit       (ack_hit),
    .taken     (taken)
  );

  dbs_lane_shift #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_shift (
    .din   (wdata_q),
    .shift (taken),
    .dout  (wdata_shifted)
  );

  dbs_read_merge #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES), .CNT_W(CNT_W)) u_merge (
    .acc      (rdata_q),
    .bus_data (bus_rdata),
    .base     (done_q),
    .taken    (taken),
    .merged   (rdata_merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= '0;
      write_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q <= ST_CYCLE;
            addr_q  <= req_addr;
            wdata_q <= req_write ? req_wdata : '0;
            rdata_q <= '0;
            done_q  <= '0;
            write_q <= req_write;
          end
        end
        ST_CYCLE: begin
          if (ack_hit) begin
            addr_q  <= addr_q + ADDR_W'(taken);
            wdata_q <= wdata_shifted;
            if (!write_q) rdata_q <= rdata_merged;
            done_q  <= next_done;
            state_q <= (next_done == CNT_W'(NUM_LANES)) ? ST_RESP : ST_GAP;
          end
        end
        ST_GAP:  state_q <= ST_CYCLE;
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign bus_strobe = (state_q == ST_CYCLE);
  assign rsp_valid  = (state_q == ST_RESP);
  assign rsp_rdata  = rdata_q;
  assign bus_addr   = addr_q;
  assign bus_wdata  = wdata_q;
  assign bus_write  = write_q;
endmodule

// File: rtl/dbs_sequencer_checker.sv
module dbs_sequencer_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              bus_strobe,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [1:0]        bus_ack
);
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> bus_strobe && bus_addr == $past(req_addr) && bus_write == $past(req_write)); // R1

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && bus_ack == 2'b00 |=> bus_strobe && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)); // R2

  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && bus_ack != 2'b00 |=> !bus_strobe); // R3

  AST_GAP_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !bus_strobe && !rsp_valid |=> bus_strobe); // R4

  AST_FULL_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe && bus_ack == 2'b11 |=> rsp_valid); // R5

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R7

  AST_RSP_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready); // R7

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, bus_strobe, rsp_valid})); // R8
endmodule

bind dbs_sequencer dbs_sequencer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .bus_strobe (bus_strobe),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ack    (bus_ack)
);

// File: tb/dbs_sequencer_test.sv
`timescale 1ns/1ps
module dbs_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_rdata;
  logic        bus_strobe;
  logic        bus_write;
  logic [23:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic [1:0]  bus_ack = 2'b00;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dbs_sequencer uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_phase = 0;   // 0 idle, 1 bus cycle, 2 gap, 3 response
  int          m_moved = 0;
  bit          m_wr = 0;
  logic [23:0] m_addr = '0;
  logic [31:0] m_wdata = '0;
  logic [31:0] m_rdata = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_moved = 0; m_wr = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
    end else begin
      case (m_phase)
        0: if (req_valid) begin
          m_phase = 1; m_moved = 0; m_wr = req_write; m_addr = req_addr;
          m_wdata = req_write ? req_wdata : 32'h0; m_rdata = '0;
        end
        1: if (bus_ack != 2'b00) begin
          int w;
          w = (bus_ack == 2'b11) ? 4 : (bus_ack == 2'b10) ? 2 : 1;
          if (w > 4 - m_moved) w = 4 - m_moved;
          if (!m_wr)
            for (int j = 0; j < w; j++)
              m_rdata[31-8*(m_moved+j) -: 8] = bus_rdata[31-8*j -: 8];
          m_wdata = m_wdata << (8 * w);
          m_addr  = m_addr + 24'(w);
          m_moved = m_moved + w;
          m_phase = (m_moved == 4) ? 3 : 2;
        end
        2: m_phase = 1;
        default: if (rsp_ready) m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit ok;
      ok = (req_ready == (m_phase == 0)) && (bus_strobe == (m_phase == 1)) &&
           (rsp_valid == (m_phase == 3));
      check(ok, "R8", "phase {ready,strobe,rsp}", {29'd0, req_ready, bus_strobe, rsp_valid},
            {29'd0, m_phase == 0, m_phase == 1, m_phase == 3});
      if (m_phase == 1) begin
        check(bus_addr == m_addr, "R4", "bus_addr", {8'd0, bus_addr}, {8'd0, m_addr});
        check(bus_wdata == m_wdata, "R4", "bus_wdata", bus_wdata, m_wdata);
        check(bus_write == m_wr, "R1", "bus_write", {31'd0, bus_write}, {31'd0, m_wr});
      end
      if (m_phase == 3)
        check(rsp_rdata == m_rdata, "R6", "rsp_rdata", rsp_rdata, m_rdata);
    end
  end

  // ---------------- target side ----------------
  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] * 8'd37) ^ 8'hA5 ^ a[23:16];
  endfunction

  function automatic logic [1:0] port_code(input logic [23:0] a);
    case (a[23:22])
      2'd0: return 2'b11;
      2'd1: return 2'b10;
      2'd2: return 2'b01;
      default: case (a[1:0])
        2'd0: return 2'b01;
        2'd1: return 2'b10;
        2'd2: return 2'b01;
        default: return 2'b11;
      endcase
    endcase
  endfunction

  task automatic run_txn(input bit wr, input logic [23:0] a, input logic [31:0] d,
                         input int waits, input bit junk);
    int moved = 0, ncyc = 0, wcnt = 0, exp_cyc;
    logic [31:0] got = '0, exp_r, held;
    case (a[23:22])
      2'd0: exp_cyc = 1;
      2'd1: exp_cyc = 2;
      2'd2: exp_cyc = 4;
      default: exp_cyc = 3;
    endcase
    for (int k = 0; k < 4; k++) exp_r[31-8*k -: 8] = mem_byte(a + 24'(k));

    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_wdata = 32'hBAD0BAD0;
    check(bus_strobe && bus_addr == a, "R1", "start cycle addr", {8'd0, bus_addr}, {8'd0, a});
    if (wr) check(bus_wdata == d, "R1", "first write data", bus_wdata, d);
    while (!rsp_valid) begin
      if (bus_strobe) begin
        if (wcnt < waits) begin
          bus_ack = 2'b00; wcnt++;
          bus_rdata = 32'hDEADBEEF;
        end else begin
          logic [1:0] code;
          int w;
          wcnt = 0;
          code = port_code(bus_addr);
          w = (code == 2'b11) ? 4 : (code == 2'b10) ? 2 : 1;
          for (int j = 0; j < 4; j++)
            bus_rdata[31-8*j -: 8] = (j < w) ? mem_byte(bus_addr + 24'(j)) : 8'hEE;
          if (w > 4 - moved) w = 4 - moved;
          if (wr)
            for (int j = 0; j < w; j++) got[31-8*(moved+j) -: 8] = bus_wdata[31-8*j -: 8];
          bus_ack = code;
          moved += w;
          ncyc++;
        end
      end else begin
        bus_ack = junk ? 2'b11 : 2'b00;
        bus_rdata = 32'h5A5A5A5A;
      end
      @(posedge clk); #1;
    end
    bus_ack = junk ? 2'b11 : 2'b00;
    check(ncyc == exp_cyc, "R5", "bus cycle count", 32'(ncyc), 32'(exp_cyc));
    if (wr) begin
      check(got == d, "R4", "bytes received by target", got, d);
      check(rsp_rdata == 32'h0, "R7", "write rdata", rsp_rdata, 32'h0);
    end else
      check(rsp_rdata == exp_r, "R6", "assembled read", rsp_rdata, exp_r);
    held = rsp_rdata;
    rsp_ready = 1'b0;
    @(posedge clk); #1;
    check(rsp_valid && rsp_rdata == held, "R7", "response held under back-pressure", rsp_rdata, held);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    check(req_ready && !rsp_valid, "R7", "idle after response", {31'd0, req_ready}, 32'd1);
    bus_ack = 2'b00;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(req_ready && !bus_strobe && !rsp_valid, "R1", "reset state",
          {29'd0, req_ready, bus_strobe, rsp_valid}, 32'b100);
    rst_n = 1'b1;
    run_txn(1, 24'h000100, 32'h11223344, 0, 0);   // R5 full-width write
    run_txn(0, 24'h000200, 32'h0, 0, 0);          // R6 full-width read
    run_txn(1, 24'h400300, 32'hA1B2C3D4, 2, 0);   // R2 waits, halfword port
    run_txn(0, 24'h400400, 32'h0, 1, 1);          // R3 stray acks
    run_txn(1, 24'h800500, 32'hCAFEF00D, 0, 1);   // R4 byte port
    run_txn(0, 24'h800600, 32'h0, 3, 0);          // R6 byte port read
    run_txn(1, 24'hC00700, 32'h0F1E2D3C, 0, 0);   // R5 mixed widths
    run_txn(0, 24'hC00800, 32'h0, 1, 1);          // R5 mixed read
    for (int i = 0; i < 24; i++) begin
      logic [23:0] a;
      a = {$urandom_range(3, 0) > 0 ? 2'($urandom_range(3, 0)) : 2'd0, 14'($urandom), 8'($urandom) & 8'hFC};
      run_txn(1'($urandom), a, $urandom, $urandom_range(2, 0), 1'($urandom));
    end
    finish_run();
  end
endmodule